// File: doc/BRIEF.md
# Sleep Mode and Wake Controller

This block is the power-management sequencer of a small microcontroller core. Software writes a control word that holds a sleep-enable bit, a 3-bit mode code and a request to switch the brown-out detector off. When the core reports that it has executed a sleep instruction while the enable bit is set, the controller enters the selected low-power mode. It then drives one clock-enable line per clock domain (CPU, flash, I/O, ADC, asynchronous timer), the main-oscillator enable and the brown-out-detector disable line.

While asleep it watches eight interrupt wake sources. The core's interrupt logic presents them already qualified by their enable bits, and the controller accepts only those that are valid for the current mode. An accepted interrupt starts an oscillator start-up wait. That wait is zero cycles when the main oscillator was kept running and a programmable count otherwise. A fixed four-cycle halt follows, and then a one-cycle pulse tells the core to service the interrupt and continue after the sleep instruction. A reset request that arrives during sleep takes a separate exit: after the start-up wait it raises a reset-vector pulse instead, with no halt. The controller never issues any clear to architectural state.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: A sleep instruction pulse enters sleep only when control bit 0 (sleep enable) is 1 in the cycle of the pulse; with the bit at 0 the block stays awake and all clock enables stay 1.
- R2: Control bits [3:1] select the mode: 000 Idle, 001 ADC-quiet, 010 Deep-off, 011 Timer-keep, 110 Standby, 111 Timer-standby; 100 and 101 behave as Idle. clk_en bit 0 is CPU, 1 flash, 2 I/O, 3 ADC, 4 async timer. While sleeping, clk_en is 11100 in Idle, 11000 in ADC-quiet, 00000 in Deep-off and Standby, and 10000 in Timer-keep and Timer-standby.
- R3: While sleeping, osc_en is 0 in Deep-off and Timer-keep and 1 in every other mode; osc_en is 1 whenever the block is awake.
- R4: irq_pend bits are 0 external level, 1 pin change, 2 address match, 3 async timer, 4 memory ready, 5 ADC, 6 watchdog, 7 other I/O. Idle accepts all eight, ADC-quiet accepts bits 0 to 6, Deep-off and Standby accept bits 0, 1, 2 and 6, and Timer-keep and Timer-standby accept bits 0, 1, 2, 3 and 6. A rejected source leaves the block asleep.
- R5: After an accepted interrupt, core_halt stays 1 for the start-up wait plus one cycle and then four halt cycles. The wait is 0 when the mode kept the oscillator on and startup_cycles otherwise. resume_pulse is then 1 for one cycle as core_halt falls.
- R6: sys_rst_req during sleep takes priority over interrupts. core_halt stays 1 for the start-up wait plus one cycle, and then rstvec_pulse is 1 for one cycle while resume_pulse stays 0.
- R7: bdis is 1 only while sleeping in Deep-off, Timer-keep, Standby or Timer-standby with control bit 4 (brown-out-off request) set, and is 0 otherwise.
- R8: While awake, irq_pend and sys_rst_req have no effect: core_halt, resume_pulse and rstvec_pulse stay 0.
- R9: The mode and brown-out request are captured at sleep entry; control writes during sleep do not change clk_en, osc_en or bdis.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| ctl_wr | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 5 | Control word: [0] sleep enable, [3:1] mode, [4] brown-out-off request |
| slp_insn | input | 1 | One-cycle pulse: core executed a sleep instruction |
| startup_cycles | input | CNT_W | Oscillator start-up wait in cycles |
| irq_pend | input | 8 | Enabled pending interrupt sources |
| sys_rst_req | input | 1 | Reset request from the reset logic |
| clk_en | output | 5 | Per-domain clock enables |
| osc_en | output | 1 | Main oscillator enable |
| bdis | output | 1 | Brown-out detector disable |
| sleeping | output | 1 | Block is in a sleep mode |
| core_halt | output | 1 | Core must not execute |
| resume_pulse | output | 1 | Service interrupt and continue after the sleep instruction |
| rstvec_pulse | output | 1 | Restart the core at the reset vector |

## Verification
The assertions assume that slp_insn is a single-cycle pulse issued only while the core runs. They also assume that irq_pend and sys_rst_req are sampled at clock edges, and that startup_cycles holds steady across a wake. The stimulus drives every input on the falling edge and deasserts each pulse after one cycle. For each of the eight mode codes it sweeps every single wake source, both brown-out requests and a reset exit. It also floods all sources and the reset request while the block is awake to confirm they are ignored. Expected gating, masks and halt lengths are derived in the bench from the mode tables above.

// File: rtl/slp_pkg.sv
// Shared types for the sleep/wake controller: mode codes, sequencer
// states, domain and wake-source indices, per-mode configuration.
package slp_pkg;
    localparam int NDOM  = 5;
    localparam int NWAKE = 8;

    // clock domain index within clk_en
    localparam int D_CPU   = 0;
    localparam int D_FLASH = 1;
    localparam int D_IO    = 2;
    localparam int D_ADC   = 3;
    localparam int D_ASYNC = 4;

    // wake source index within irq_pend
    localparam int W_EXT   = 0;
    localparam int W_PIN   = 1;
    localparam int W_ADDR  = 2;
    localparam int W_TMR   = 3;
    localparam int W_NVM   = 4;
    localparam int W_ADC   = 5;
    localparam int W_WDOG  = 6;
    localparam int W_OTHER = 7;

    typedef enum logic [2:0] {
        M_IDLE  = 3'b000,
        M_QUIET = 3'b001,
        M_DEEP  = 3'b010,
        M_TKEEP = 3'b011,
        M_RSV4  = 3'b100,
        M_RSV5  = 3'b101,
        M_STBY  = 3'b110,
        M_TSTBY = 3'b111
    } slp_mode_e;

    typedef enum logic [1:0] {
        S_RUN   = 2'd0,
        S_SLEEP = 2'd1,
        S_START = 2'd2,
        S_HALT  = 2'd3
    } seq_st_e;

    typedef struct packed {
        logic [NDOM-1:0]  clk_on;
        logic             osc_on;
        logic [NWAKE-1:0] wake_ok;
        logic             bod_off_ok;
    } mode_cfg_t;
endpackage

// File: rtl/slp_mode_decode.sv
// Mode decoder: maps the captured mode code to the clock domains left
// running, the oscillator state, the accepted wake sources and whether
// the brown-out detector may be turned off. Purely combinational.
// Assumes reserved codes are to behave as Idle.
module slp_mode_decode
    import slp_pkg::*;
(
    input  slp_mode_e mode,
    output mode_cfg_t cfg
);
    // Per-mode configuration lookup
    always_comb begin
        cfg = '0;
        cfg.clk_on[D_ASYNC] = 1'b1;
        cfg.osc_on          = 1'b1;
        cfg.wake_ok[W_EXT]  = 1'b1;
        cfg.wake_ok[W_PIN]  = 1'b1;
        cfg.wake_ok[W_ADDR] = 1'b1;
        cfg.wake_ok[W_WDOG] = 1'b1;
        cfg.wake_ok[W_TMR]  = 1'b1;
        unique case (mode)
            M_QUIET: begin
                cfg.clk_on[D_ADC]   = 1'b1;
                cfg.wake_ok[W_NVM]  = 1'b1;
                cfg.wake_ok[W_ADC]  = 1'b1;
            end
            M_DEEP: begin
                cfg.clk_on[D_ASYNC] = 1'b0;
                cfg.osc_on          = 1'b0;
                cfg.wake_ok[W_TMR]  = 1'b0;
                cfg.bod_off_ok      = 1'b1;
            end
            M_TKEEP: begin
                cfg.osc_on          = 1'b0;
                cfg.bod_off_ok      = 1'b1;
            end
            M_STBY: begin
                cfg.clk_on[D_ASYNC] = 1'b0;
                cfg.wake_ok[W_TMR]  = 1'b0;
                cfg.bod_off_ok      = 1'b1;
            end
            M_TSTBY: begin
                cfg.bod_off_ok      = 1'b1;
            end
            default: begin
                cfg.clk_on[D_IO]    = 1'b1;
                cfg.clk_on[D_ADC]   = 1'b1;
                cfg.wake_ok         = '1;
            end
        endcase
    end
endmodule

// File: rtl/slp_wake_detect.sv
// Wake qualifier: filters pending interrupts through the mode's accepted
// set and gives a reset request priority over any interrupt. Only active
// while the sequencer is in the sleep state. Combinational.
module slp_wake_detect
    import slp_pkg::*;
#(
    parameter int NSRC = NWAKE
) (
    input  logic [NSRC-1:0] irq_pend,
    input  logic [NSRC-1:0] wake_ok,
    input  logic            sys_rst_req,
    input  logic            in_sleep,
    output logic            wake_irq,
    output logic            wake_rst
);
    logic [NSRC-1:0] accepted;

    // Mask sources by mode and arbitrate reset over interrupts
    always_comb begin
        accepted = irq_pend & wake_ok;
        wake_rst = in_sleep && sys_rst_req;
        wake_irq = in_sleep && !sys_rst_req && (|accepted);
    end
endmodule

// File: rtl/slp_seq.sv
// Sleep sequencer: run -> sleep on an enabled sleep instruction; on a
// wake it counts the oscillator start-up wait, then (interrupt path) a
// fixed halt, and finally pulses resume or reset-vector. Assumes
// slp_insn is a one-cycle pulse and startup_cycles is stable on wake.
module slp_seq
    import slp_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int HALT_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slp_insn,
    input  logic             se,
    input  logic             osc_kept,
    input  logic [CNT_W-1:0] startup_cycles,
    input  logic             wake_irq,
    input  logic             wake_rst,
    output seq_st_e          st,
    output logic             enter,
    output logic             resume_pulse,
    output logic             rstvec_pulse
);
    localparam int HW = (HALT_CYC > 1) ? $clog2(HALT_CYC) : 1;
    localparam logic [HW-1:0] HALT_LOAD = HW'(HALT_CYC - 1);

    logic [CNT_W-1:0] wait_cnt;
    logic [HW-1:0]    halt_cnt;
    logic             rst_path;

    // Sleep entry condition
    always_comb enter = (st == S_RUN) && slp_insn && se;

    // State, counters and exit pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st           <= S_RUN;
            wait_cnt     <= '0;
            halt_cnt     <= '0;
            rst_path     <= 1'b0;
            resume_pulse <= 1'b0;
            rstvec_pulse <= 1'b0;
        end else begin
            resume_pulse <= 1'b0;
            rstvec_pulse <= 1'b0;
            unique case (st)
                S_RUN: begin
                    if (enter) st <= S_SLEEP;
                end
                S_SLEEP: begin
                    if (wake_rst || wake_irq) begin
                        st       <= S_START;
                        rst_path <= wake_rst;
                        wait_cnt <= osc_kept ? '0 : startup_cycles;
                    end
                end
                S_START: begin
                    if (wait_cnt != '0) begin
                        wait_cnt <= wait_cnt - 1'b1;
                    end else if (rst_path) begin
                        st           <= S_RUN;
                        rstvec_pulse <= 1'b1;
                    end else begin
                        st       <= S_HALT;
                        halt_cnt <= HALT_LOAD;
                    end
                end
                S_HALT: begin
                    if (halt_cnt != '0) begin
                        halt_cnt <= halt_cnt - 1'b1;
                    end else begin
                        st           <= S_RUN;
                        resume_pulse <= 1'b1;
                    end
                end
                default: st <= S_RUN;
            endcase
        end
    end

    // R1
    no_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RUN && slp_insn && !se) |=> (st == S_RUN));

    // R5
    halt_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume_pulse |-> ($past(st == S_HALT, 1) && $past(st == S_HALT, 4)));

    // R5
    fast_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_SLEEP && wake_irq && osc_kept) |=> (st == S_START) ##1 (st == S_HALT));

    // R6
    exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(resume_pulse && rstvec_pulse));
endmodule

// File: rtl/sleep_wake_ctrl.sv
// Sleep/wake controller top: holds the control word, captures mode and
// brown-out request at sleep entry, and drives clock-domain enables, the
// oscillator enable and the brown-out disable from the sequencer state.
// Assumes inputs are synchronous to clk. Issues no clear on wake.
module sleep_wake_ctrl
    import slp_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int HALT_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [4:0]       ctl_wdata,
    input  logic             slp_insn,
    input  logic [CNT_W-1:0] startup_cycles,
    input  logic [7:0]       irq_pend,
    input  logic             sys_rst_req,
    output logic [4:0]       clk_en,
    output logic             osc_en,
    output logic             bdis,
    output logic             sleeping,
    output logic             core_halt,
    output logic             resume_pulse,
    output logic             rstvec_pulse
);
    logic      ctl_se;
    logic      ctl_bod;
    slp_mode_e ctl_mode;
    slp_mode_e act_mode;
    logic      act_bod;
    mode_cfg_t cfg;
    seq_st_e   st;
    logic      enter;
    logic      wake_irq;
    logic      wake_rst;
    logic      gated;

    // Control word register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_se   <= 1'b0;
            ctl_bod  <= 1'b0;
            ctl_mode <= M_IDLE;
        end else if (ctl_wr) begin
            ctl_se   <= ctl_wdata[0];
            ctl_mode <= slp_mode_e'(ctl_wdata[3:1]);
            ctl_bod  <= ctl_wdata[4];
        end
    end

    // Capture the active mode at sleep entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_mode <= M_IDLE;
            act_bod  <= 1'b0;
        end else if (enter) begin
            act_mode <= ctl_mode;
            act_bod  <= ctl_bod;
        end
    end

    slp_mode_decode u_dec (
        .mode (act_mode),
        .cfg  (cfg)
    );

    slp_wake_detect #(.NSRC(NWAKE)) u_wake (
        .irq_pend    (irq_pend),
        .wake_ok     (cfg.wake_ok),
        .sys_rst_req (sys_rst_req),
        .in_sleep    (st == S_SLEEP),
        .wake_irq    (wake_irq),
        .wake_rst    (wake_rst)
    );

    slp_seq #(.CNT_W(CNT_W), .HALT_CYC(HALT_CYC)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .slp_insn       (slp_insn),
        .se             (ctl_se),
        .osc_kept       (cfg.osc_on),
        .startup_cycles (startup_cycles),
        .wake_irq       (wake_irq),
        .wake_rst       (wake_rst),
        .st             (st),
        .enter          (enter),
        .resume_pulse   (resume_pulse),
        .rstvec_pulse   (rstvec_pulse)
    );

    // Domain and oscillator outputs from state and captured mode
    always_comb begin
        sleeping  = (st == S_SLEEP);
        gated     = (st == S_SLEEP) || (st == S_START);
        core_halt = (st != S_RUN);
        clk_en    = gated ? cfg.clk_on : '1;
        osc_en    = sleeping ? cfg.osc_on : 1'b1;
        bdis      = sleeping && cfg.bod_off_ok && act_bod;
    end

    // R2
    gate_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleeping |-> (!clk_en[D_CPU] && !clk_en[D_FLASH]));

    // R4
    deep_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleeping && act_mode == M_DEEP && !sys_rst_req
         && (irq_pend & 8'b0100_0111) == 8'h00) |=> sleeping);

    // R7
    bdis_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bdis |-> (sleeping && act_mode inside {M_DEEP, M_TKEEP, M_STBY, M_TSTBY}));

    // R8
    awake_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_halt && !slp_insn) |=> !core_halt);
endmodule

// File: tb/sim_sleep_wake_ctrl.sv
`timescale 1ns/1ps
module sim_sleep_wake_ctrl;
    localparam int CNT_W = 8;
    localparam int SU    = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ctl_wr = 1'b0;
    logic [4:0]       ctl_wdata = '0;
    logic             slp_insn = 1'b0;
    logic [CNT_W-1:0] startup_cycles = CNT_W'(SU);
    logic [7:0]       irq_pend = '0;
    logic             sys_rst_req = 1'b0;
    logic [4:0]       clk_en;
    logic             osc_en, bdis, sleeping, core_halt, resume_pulse, rstvec_pulse;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;

    sleep_wake_ctrl #(.CNT_W(CNT_W), .HALT_CYC(4)) u0 (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .slp_insn(slp_insn), .startup_cycles(startup_cycles),
        .irq_pend(irq_pend), .sys_rst_req(sys_rst_req), .clk_en(clk_en),
        .osc_en(osc_en), .bdis(bdis), .sleeping(sleeping),
        .core_halt(core_halt), .resume_pulse(resume_pulse),
        .rstvec_pulse(rstvec_pulse)
    );

    // expected tables from the requirements
    function automatic logic [4:0] exp_clk(input int m);
        case (m)
            1:       return 5'b11000;
            2, 6:    return 5'b00000;
            3, 7:    return 5'b10000;
            default: return 5'b11100;
        endcase
    endfunction

    function automatic logic exp_osc(input int m);
        return !(m == 2 || m == 3);
    endfunction

    function automatic logic [7:0] exp_wake(input int m);
        case (m)
            1:       return 8'h7F;
            2, 6:    return 8'h47;
            3, 7:    return 8'h4F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic exp_bod(input int m);
        return (m == 2 || m == 3 || m == 6 || m == 7);
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
    endtask

    task automatic count_halt(output int n);
        n = 0;
        while (core_halt && n < 200) begin
            n++;
            step();
        end
    endtask

    task automatic run_trial(input int m, input bit se, input bit bod, input int src, input bit use_rst);
        int n;
        int lw;
        logic [4:0] ce;
        logic oe;
        lw = exp_osc(m) ? 0 : SU;
        ctl_wr = 1'b1;
        ctl_wdata = {bod, 3'(m), se};
        irq_pend = 8'hFF;
        sys_rst_req = 1'b1;
        step();
        ctl_wr = 1'b0;
        irq_pend = '0;
        sys_rst_req = 1'b0;
        // R8: sources and reset request ignored while awake
        chk(!core_halt && !resume_pulse && !rstvec_pulse, "R8 awake", int'(core_halt), 0);
        slp_insn = 1'b1;
        step();
        slp_insn = 1'b0;
        // R1: entry only with enable bit
        chk(sleeping == se, "R1 entry", int'(sleeping), int'(se));
        if (!se) begin
            chk(clk_en == 5'b11111 && !core_halt, "R1 no-op clocks", int'(clk_en), 31);
            return;
        end
        // R2, R3, R7: gating in sleep
        chk(clk_en == exp_clk(m), "R2 clk_en", int'(clk_en), int'(exp_clk(m)));
        chk(osc_en == exp_osc(m), "R3 osc_en", int'(osc_en), int'(exp_osc(m)));
        chk(bdis == (bod && exp_bod(m)), "R7 bdis", int'(bdis), int'(bod && exp_bod(m)));
        ce = clk_en;
        oe = osc_en;
        // R9: control write during sleep has no effect
        ctl_wr = 1'b1;
        ctl_wdata = {~bod, 3'(m) ^ 3'b010, 1'b1};
        step();
        ctl_wr = 1'b0;
        chk(clk_en == ce && osc_en == oe && bdis == (bod && exp_bod(m)) && sleeping,
            "R9 captured mode", int'(clk_en), int'(ce));
        if (use_rst) begin
            sys_rst_req = 1'b1;
            irq_pend = 8'hFF;
            step();
            sys_rst_req = 1'b0;
            irq_pend = '0;
            count_halt(n);
            // R6: reset path
            chk(n == lw + 1, "R6 halt length", n, lw + 1);
            chk(rstvec_pulse && !resume_pulse, "R6 reset vector", int'(rstvec_pulse), 1);
        end else begin
            irq_pend = 8'(1 << src);
            step();
            irq_pend = '0;
            // R4: per-mode wake mask
            chk(sleeping == !exp_wake(m)[src], "R4 wake mask", int'(sleeping), int'(!exp_wake(m)[src]));
            if (sleeping) begin
                irq_pend = 8'h01;
                step();
                irq_pend = '0;
            end
            count_halt(n);
            // R5: start-up wait plus four halt cycles
            chk(n == lw + 5, "R5 halt length", n, lw + 5);
            chk(resume_pulse && !rstvec_pulse, "R5 resume pulse", int'(resume_pulse), 1);
        end
        step();
        chk(!resume_pulse && !rstvec_pulse && !core_halt, "R5 single pulse", int'(resume_pulse), 0);
    endtask

    initial begin
        step();
        step();
        // reset state
        chk(clk_en == 5'b11111 && osc_en && !bdis && !sleeping && !core_halt,
            "R1 reset state", int'(clk_en), 31);
        rst_n = 1'b1;
        step();
        for (int m = 0; m < 8; m++) begin
            run_trial(m, 1'b0, 1'b1, 0, 1'b0);
            for (int s = 0; s < 8; s++) begin
                run_trial(m, 1'b1, 1'(s & 1), s, 1'b0);
            end
            run_trial(m, 1'b1, 1'b1, 0, 1'b1);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule